// File: doc/BRIEF.md
# Two-Wire Bus Target with Host Status Flags

This block is the target side of a two-wire serial bus (I2C). It watches the clock and data lines for START, repeated START and STOP. After each START it reads a 7-bit address and a direction bit. When the address equals the programmed one, it pulls the data line low in the acknowledge slot. When it does not, it stays silent until the next START or STOP.

In a master write, every byte is moved into a receive holding register and acknowledged. In a master read, bytes are taken from a transmit holding register and shifted out MSB first. The data line is modelled as an open-drain pad through a single output-enable: asserted means the pad pulls low.

The host sees the block through simple strobes: one writes the transmit register, one reads the receive register, and one reads the status. The status bits are access-active, direction, end-of-access, transmit-ready, receive-ready and overrun.

Top module: `twi_target`

## Requirements
- R1: After a START or repeated START, the next eight bits sampled on SCL rising edges (MSB first) form a 7-bit address followed by a direction bit (1 = master read). When the address equals `own_addr`, `sda_oe` is held high through the ninth clock (ACK).
- R2: When the address differs, `sda_oe` stays low through the acknowledge slot and until the next START or STOP. Bytes clocked in that time are not stored and change no flag.
- R3: A matching address sets `acc_active` and loads `acc_dir` with the direction bit. `acc_dir` changes at no other time.
- R4: In a master write, each received byte is acknowledged and appears on `rhr_data`, and `rx_ready` is set. A one-cycle `rhr_rd` strobe clears `rx_ready`.
- R5: A byte that arrives while `rx_ready` is set, with no `rhr_rd` in that cycle, replaces the held byte and sets `rx_overrun`. `stat_rd` clears `rx_overrun`. The byte is stored on the third clock edge after SCL rises for its eighth bit at the pin. An `rhr_rd` on that same edge leaves `rx_ready` set and `rx_overrun` clear.
- R6: In a master read, the transmit register is copied into the shifter on the SCL fall that ends the preceding ACK slot. That copy clears `tx_ready`. The bits are driven MSB first. `tx_ready` is set again at the master's acknowledge bit, whether that bit is ACK or NACK. A host write of the transmit register leaves `tx_ready` unchanged.
- R7: After an ACK from the master, the next byte is loaded from the transmit register. After a NACK, `sda_oe` stays low until the next START or STOP.
- R8: A STOP clears `acc_active`. `acc_end` is set in the cycle `acc_active` falls and cleared by `stat_rd`. A STOP during an inactive period leaves `acc_end` clear.
- R9: A repeated START followed by a matching address keeps `acc_active` set and reloads `acc_dir`. A repeated START followed by a different address clears `acc_active` and sets `acc_end`.
- R10: After reset: `sda_oe`, `acc_active`, `acc_end`, `rx_ready` and `rx_overrun` are 0, and `tx_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | Pad pull-down enable for the data line |
| own_addr | input | 7 | Programmed target address |
| thr_wr | input | 1 | Host write strobe for the transmit register |
| thr_data | input | 8 | Data for the transmit register |
| rhr_rd | input | 1 | Host read strobe for the receive register |
| rhr_data | output | 8 | Receive holding register |
| stat_rd | input | 1 | Host status read strobe; clears end and overrun flags |
| acc_active | output | 1 | Addressed access in progress |
| acc_dir | output | 1 | Direction of the access, 1 = master read |
| acc_end | output | 1 | An access has ended since the last status read |
| tx_ready | output | 1 | Transmit register may be written |
| rx_ready | output | 1 | Receive register holds an unread byte |
| rx_overrun | output | 1 | A byte was overwritten before it was read |

## Verification
The interesting collision is a completed byte arriving in the same clock cycle as the host's read strobe on the receive register. The bench provokes it by counting the known synchroniser latency from the SCL rise of the eighth bit. It places a single `rhr_rd` pulse exactly on the storing edge, while the previous byte is still unread. The result is judged at the pins: the new byte must be held, `rx_ready` must stay set, and no overrun may be flagged. A separate run without the read shows that the overrun does appear.

// File: rtl/twi_pkg.sv
package twi_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_WAIT,
    ST_ACK_DRIVE,
    ST_RX,
    ST_TX,
    ST_TX_ACK,
    ST_TX_NEXT,
    ST_SKIP
  } twi_state_e;

  function automatic logic [7:0] shift_in(input logic [7:0] sh, input logic b);
    return {sh[6:0], b};
  endfunction

  function automatic logic addr_hit(input logic [7:0] frame, input logic [6:0] own);
    return frame[7:1] == own;
  endfunction

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_p, sda_p;
  logic              scl_q, sda_q;
  logic              scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_p <= {scl_p[STAGES-2:0], scl_in};
      sda_p <= {sda_p[STAGES-2:0], sda_in};
      scl_q <= scl_p[STAGES-1];
      sda_q <= sda_p[STAGES-1];
    end
  end

  assign scl_s     = scl_p[STAGES-1];
  assign sda_s     = sda_p[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/twi_byte_engine.sv
module twi_byte_engine
  import twi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [6:0] own_addr,
  input  logic [7:0] thr_q,
  output logic       sda_oe,
  output logic       addr_match,
  output logic       addr_miss,
  output logic       rw_bit,
  output logic       rx_done,
  output logic [7:0] rx_byte,
  output logic       tx_load,
  output logic       tx_acked
);
  twi_state_e state;
  logic [3:0] bitcnt;
  logic [7:0] sh;
  logic       dir_r;
  logic [7:0] nxt;
  logic       last_in;

  assign nxt        = shift_in(sh, sda_s);
  assign last_in    = scl_rise && (bitcnt == 4'd7);
  assign addr_match = (state == ST_ADDR) && last_in && addr_hit(nxt, own_addr);
  assign addr_miss  = (state == ST_ADDR) && last_in && !addr_hit(nxt, own_addr);
  assign rw_bit     = nxt[0];
  assign rx_done    = (state == ST_RX) && last_in;
  assign rx_byte    = nxt;
  assign tx_acked   = (state == ST_TX_ACK) && scl_rise;
  assign tx_load    = scl_fall && (((state == ST_ACK_DRIVE) && dir_r) || (state == ST_TX_NEXT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      bitcnt <= '0;
      sh     <= '0;
      dir_r  <= 1'b0;
      sda_oe <= 1'b0;
    end else if (start_det) begin
      state  <= ST_ADDR;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR, ST_RX: if (scl_rise) begin
          sh     <= nxt;
          bitcnt <= bitcnt + 4'd1;
          if (bitcnt == 4'd7) begin
            if (state == ST_RX) state <= ST_ACK_WAIT;
            else if (addr_hit(nxt, own_addr)) begin
              dir_r <= nxt[0];
              state <= ST_ACK_WAIT;
            end else state <= ST_SKIP;
          end
        end
        ST_ACK_WAIT: if (scl_fall) begin
          sda_oe <= 1'b1;
          state  <= ST_ACK_DRIVE;
        end
        ST_ACK_DRIVE, ST_TX_NEXT: if (scl_fall) begin
          bitcnt <= '0;
          if (tx_load) begin
            sh     <= thr_q;
            sda_oe <= ~thr_q[7];
            state  <= ST_TX;
          end else begin
            sda_oe <= 1'b0;
            state  <= ST_RX;
          end
        end
        ST_TX: begin
          if (scl_rise) bitcnt <= bitcnt + 4'd1;
          else if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              sda_oe <= 1'b0;
              state  <= ST_TX_ACK;
            end else begin
              sh     <= sh << 1;
              sda_oe <= ~sh[6];
            end
          end
        end
        ST_TX_ACK: if (scl_rise) state <= sda_s ? ST_SKIP : ST_TX_NEXT;
        default: ;
      endcase
    end
  end

  assert_quiet_unaddressed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE || state == ST_ADDR || state == ST_SKIP) |-> !sda_oe);

  assert_nack_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_acked && sda_s && !start_det && !stop_det) |=> (!sda_oe && state == ST_SKIP));

endmodule

// File: rtl/twi_target.sv
module twi_target #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_oe,
  input  logic [6:0] own_addr,
  input  logic       thr_wr,
  input  logic [7:0] thr_data,
  input  logic       rhr_rd,
  output logic [7:0] rhr_data,
  input  logic       stat_rd,
  output logic       acc_active,
  output logic       acc_dir,
  output logic       acc_end,
  output logic       tx_ready,
  output logic       rx_ready,
  output logic       rx_overrun
);
  logic       sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic       addr_match, addr_miss, rw_bit, rx_done, tx_load, tx_acked;
  logic [7:0] rx_byte;
  logic [7:0] thr_q;
  logic       access_ends;

  twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  twi_byte_engine u_engine (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .own_addr(own_addr), .thr_q(thr_q), .sda_oe(sda_oe),
    .addr_match(addr_match), .addr_miss(addr_miss), .rw_bit(rw_bit),
    .rx_done(rx_done), .rx_byte(rx_byte), .tx_load(tx_load), .tx_acked(tx_acked)
  );

  assign access_ends = acc_active && (stop_det || addr_miss);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q      <= '0;
      rhr_data   <= '0;
      acc_active <= 1'b0;
      acc_dir    <= 1'b0;
      acc_end    <= 1'b0;
      tx_ready   <= 1'b1;
      rx_ready   <= 1'b0;
      rx_overrun <= 1'b0;
    end else begin
      if (thr_wr) thr_q <= thr_data;

      if (addr_match) begin
        acc_active <= 1'b1;
        acc_dir    <= rw_bit;
      end else if (stop_det || addr_miss) acc_active <= 1'b0;

      if (access_ends) acc_end <= 1'b1;
      else if (stat_rd) acc_end <= 1'b0;

      if (tx_load) tx_ready <= 1'b0;
      else if (tx_acked) tx_ready <= 1'b1;

      if (rx_done) begin
        rhr_data <= rx_byte;
        rx_ready <= 1'b1;
      end else if (rhr_rd) rx_ready <= 1'b0;

      if (rx_done && rx_ready && !rhr_rd) rx_overrun <= 1'b1;
      else if (stat_rd) rx_overrun <= 1'b0;
    end
  end

  assert_dir_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_match |=> $stable(acc_dir));

  assert_rx_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> rx_ready);

  assert_overrun_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_overrun) |-> $past(rx_ready));

  assert_tx_flag_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> !tx_ready);

  assert_end_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(acc_active) |-> acc_end);

endmodule

// File: tb/test_twi_target.sv
module test_twi_target;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1, m_sda = 1'b1;
  logic       sda_oe, sda_line;
  logic [6:0] own_addr = 7'h5A;
  logic       thr_wr = 1'b0, rhr_rd = 1'b0, stat_rd = 1'b0;
  logic [7:0] thr_data = '0, rhr_data;
  logic       acc_active, acc_dir, acc_end, tx_ready, rx_ready, rx_overrun;
  int         n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;
  assign sda_line = m_sda & ~sda_oe;

  twi_target i_twi_target (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line), .sda_oe(sda_oe),
    .own_addr(own_addr), .thr_wr(thr_wr), .thr_data(thr_data), .rhr_rd(rhr_rd),
    .rhr_data(rhr_data), .stat_rd(stat_rd), .acc_active(acc_active), .acc_dir(acc_dir),
    .acc_end(acc_end), .tx_ready(tx_ready), .rx_ready(rx_ready), .rx_overrun(rx_overrun)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic q(); repeat (4) @(negedge clk); endtask

  task automatic bus_start();
    m_sda = 1'b1; q(); m_scl = 1'b1; q(); m_sda = 1'b0; q(); m_scl = 1'b0; q();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; q(); m_scl = 1'b1; q(); m_sda = 1'b1; q();
  endtask

  task automatic send_bit(input logic b, input logic pulse_rd);
    m_sda = b; q(); m_scl = 1'b1;
    if (pulse_rd) begin
      @(negedge clk); @(negedge clk); rhr_rd = 1'b1;
      @(negedge clk); rhr_rd = 1'b0; @(negedge clk);
    end else q();
    q(); m_scl = 1'b0; q();
  endtask

  task automatic write_byte(input logic [7:0] d, input logic pulse_rd, output logic acked);
    for (int i = 7; i >= 0; i--) send_bit(d[i], pulse_rd && i == 0);
    m_sda = 1'b1; q(); m_scl = 1'b1; q();
    acked = ~sda_line;
    q(); m_scl = 1'b0; q();
  endtask

  task automatic read_byte(input logic mack, output logic [7:0] d, output logic rdy_at_ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; q(); m_scl = 1'b1; q(); d[i] = sda_line; q(); m_scl = 1'b0; q();
    end
    m_sda = ~mack; q(); m_scl = 1'b1; q();
    rdy_at_ack = tx_ready;
    q(); m_scl = 1'b0; q();
  endtask

  task automatic host_read(output logic [7:0] d);
    @(negedge clk); d = rhr_data; rhr_rd = 1'b1; @(negedge clk); rhr_rd = 1'b0;
  endtask

  task automatic host_stat();
    @(negedge clk); stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
  endtask

  task automatic host_thr(input logic [7:0] d);
    @(negedge clk); thr_data = d; thr_wr = 1'b1; @(negedge clk); thr_wr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 sda_oe", sda_oe, 0);
    chk("R10 acc_active", acc_active, 0);
    chk("R10 acc_end", acc_end, 0);
    chk("R10 rx_ready", rx_ready, 0);
    chk("R10 rx_overrun", rx_overrun, 0);
    chk("R10 tx_ready", tx_ready, 1);
  endtask

  task automatic t_write();
    logic a; logic [7:0] d;
    bus_start();
    write_byte({7'h5A, 1'b0}, 1'b0, a);
    chk("R1 address ACK", a, 1);
    chk("R3 active", acc_active, 1);
    chk("R3 dir write", acc_dir, 0);
    write_byte(8'hC3, 1'b0, a);
    chk("R4 data ACK", a, 1);
    chk("R4 rx_ready", rx_ready, 1);
    host_read(d);
    chk("R4 rhr_data", d, 8'hC3);
    @(negedge clk);
    chk("R4 rx_ready cleared", rx_ready, 0);
    write_byte(8'h3C, 1'b0, a);
    write_byte(8'h81, 1'b0, a);
    chk("R5 overrun set", rx_overrun, 1);
    chk("R5 newest byte", rhr_data, 8'h81);
    host_stat();
    @(negedge clk);
    chk("R5 overrun cleared", rx_overrun, 0);
    host_read(d);
    bus_stop();
    chk("R8 active cleared", acc_active, 0);
    chk("R8 end set", acc_end, 1);
    host_stat();
    @(negedge clk);
    chk("R8 end cleared", acc_end, 0);
  endtask

  task automatic t_mismatch();
    logic a;
    bus_start();
    write_byte({7'h11, 1'b0}, 1'b0, a);
    chk("R2 no ACK", a, 0);
    chk("R2 not active", acc_active, 0);
    write_byte(8'hFF, 1'b0, a);
    chk("R2 byte not ACKed", a, 0);
    chk("R2 byte not stored", rx_ready, 0);
    bus_stop();
    chk("R8 no end when idle", acc_end, 0);
  endtask

  task automatic t_read();
    logic a, r; logic [7:0] d;
    host_thr(8'hA5);
    chk("R6 thr write keeps tx_ready", tx_ready, 1);
    bus_start();
    write_byte({7'h5A, 1'b1}, 1'b0, a);
    chk("R1 read address ACK", a, 1);
    chk("R3 dir read", acc_dir, 1);
    chk("R6 tx_ready cleared on load", tx_ready, 0);
    host_thr(8'h5C);
    read_byte(1'b1, d, r);
    chk("R6 first byte MSB first", d, 8'hA5);
    chk("R6 tx_ready at ack", r, 1);
    chk("R7 next byte loaded after ACK", tx_ready, 0);
    read_byte(1'b0, d, r);
    chk("R7 second byte", d, 8'h5C);
    chk("R6 tx_ready after NACK", tx_ready, 1);
    read_byte(1'b0, d, r);
    chk("R7 released after NACK", d, 8'hFF);
    bus_stop();
    chk("R8 end after read", acc_end, 1);
    host_stat();
  endtask

  task automatic t_restart();
    logic a, r; logic [7:0] d;
    host_thr(8'h0F);
    bus_start();
    write_byte({7'h5A, 1'b0}, 1'b0, a);
    bus_start();
    write_byte({7'h5A, 1'b1}, 1'b0, a);
    chk("R9 Sr match ACK", a, 1);
    chk("R9 active kept", acc_active, 1);
    chk("R9 dir reloaded", acc_dir, 1);
    chk("R9 no end on Sr match", acc_end, 0);
    read_byte(1'b0, d, r);
    chk("R6 byte after Sr", d, 8'h0F);
    bus_start();
    write_byte({7'h22, 1'b0}, 1'b0, a);
    chk("R9 Sr miss no ACK", a, 0);
    chk("R9 Sr miss clears active", acc_active, 0);
    chk("R9 Sr miss sets end", acc_end, 1);
    bus_stop();
    host_stat();
  endtask

  task automatic t_coincide();
    logic a; logic [7:0] d;
    bus_start();
    write_byte({7'h5A, 1'b0}, 1'b0, a);
    write_byte(8'h11, 1'b0, a);
    write_byte(8'h22, 1'b1, a);
    chk("R5 coincident read keeps rx_ready", rx_ready, 1);
    chk("R5 coincident read no overrun", rx_overrun, 0);
    chk("R5 coincident byte", rhr_data, 8'h22);
    host_read(d);
    bus_stop();
    host_stat();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write();
    t_mismatch();
    t_read();
    t_restart();
    t_coincide();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule